// File: doc/BRIEF.md
# Shadowed Register Readback Scrubber

This block sits between a host that programs configuration values and a set of remote registers reached over a slow register bus, such as threshold converters or settings on plug-in sensor cards. Each value the host writes is kept in a local shadow array and sent to its target. On a programmable schedule the block reads every programmed target back and compares the answer with the shadow copy. When the two differ, the shadow value is sent again and a per-target mismatch flag is raised. When a target answers with a bus error or does not answer in time, a per-target communication flag is raised instead.

The two flag vectors stay set until the host clears them. They are also folded into one summary byte that the host returns with every access it serves. The serial bus engine is not part of the block. A single-request handshake stands in for it: `bus_req` is held until the target returns `bus_ack` or `bus_err`, or until the timeout expires.

Top module: `shadow_scrub`

## Requirements
- R1: A host write stores `host_data` as the shadow value of entry `host_idx`, marks that entry valid, and causes a bus write (`bus_we`=1) of that value to that index, so the target then holds it.
- R2: At most one bus request is outstanding. Index, direction and write data stay stable while `bus_req` is high and unanswered, and `bus_req` is low for at least one cycle after an answer. Pending writes go before verify reads, and the lowest pending index goes first.
- R3: A scan starts when the interval counter, restarted at each scan start, reaches `scan_interval`. When scans are short, consecutive starts are therefore exactly `scan_interval`+1 cycles apart.
- R4: A scan reads only valid entries, one read each, in ascending index order. Invalid entries are skipped without any bus request.
- R5: A readback that differs from the shadow value sets bit i of `mis_flags` for entry i and rewrites the shadow value, which restores the target.
- R6: A `bus_err` answer, or no answer within TMO cycles of request (the request is then dropped after exactly TMO cycles high), sets bit i of `com_flags` and leaves `mis_flags` unchanged.
- R7: If the host writes the entry whose readback is in flight, that readback result is discarded: no flag is set for it, and the new value is written to the target.
- R8: Flags are sticky. They stay set after the fault goes away. A one-cycle `host_clr` clears exactly the bits set in `host_clr_mask` in both vectors.
- R9: `summary` bit 0 is the OR of `mis_flags` and bit 1 is the OR of `com_flags`, one cycle after the flags. Bits 7:2 are zero.
- R10: After reset, both flag vectors and `summary` are zero and no bus request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_idx | input | IW | Entry index of the host write |
| host_data | input | DW | Value written by the host |
| host_clr | input | 1 | Flag clear strobe |
| host_clr_mask | input | N | Write-one-to-clear mask for both flag vectors |
| scan_interval | input | CW | Cycles between scan starts, minus one |
| bus_req | output | 1 | Bus request active |
| bus_we | output | 1 | 1 for write, 0 for readback |
| bus_idx | output | IW | Target index of the request |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Target answered successfully |
| bus_err | input | 1 | Target answered with an error |
| bus_rdata | input | DW | Readback data, valid with `bus_ack` |
| mis_flags | output | N | Sticky per-target mismatch flags |
| com_flags | output | N | Sticky per-target communication-error flags |
| summary | output | 8 | Rolled-up error byte |

## Verification
The bench builds the block with N=8, DW=8, CW=8 and TMO=6. The short timeout lets a silent target be detected and its request length measured within a few cycles. The 8-bit interval lets scans be packed close together or held off for the whole write phase. A bus model with adjustable latency, per-target error and silence controls, and a back door to corrupt stored values drives the fault paths. Raising the latency to four cycles opens a window in which a host write can land on an entry whose readback is still in flight.

// File: rtl/shadow_scrub.sv
module shadow_scrub #(
  parameter int N   = 8,
  parameter int DW  = 8,
  parameter int CW  = 16,
  parameter int TMO = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [$clog2(N)-1:0] host_idx,
  input  logic [DW-1:0] host_data,
  input  logic          host_clr,
  input  logic [N-1:0]  host_clr_mask,
  input  logic [CW-1:0] scan_interval,
  output logic          bus_req,
  output logic          bus_we,
  output logic [$clog2(N)-1:0] bus_idx,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata,
  output logic [N-1:0]  mis_flags,
  output logic [N-1:0]  com_flags,
  output logic [7:0]    summary
);
  localparam int IW = $clog2(N);
  localparam int TW = $clog2(TMO);

  typedef enum logic [1:0] {IDLE, WR, RD} st_t;
  st_t st;

  logic [DW-1:0] shadow [N];
  logic [N-1:0]  vld, pend, pend_n, wr_bit, cur_bit, mis_set, com_set, clr;
  logic [IW-1:0] cur, widx;
  logic [CW-1:0] icnt;
  logic [TW-1:0] tmo;
  logic          scanning, disc;
  logic          busy, done, fail, rd_done, hit, drop, bad;
  logic          go_wr, go_rd, skip, adv, start, last;

  always_comb begin
    widx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) widx = IW'(i);
  end

  assign busy    = st != IDLE;
  assign done    = busy && (bus_ack || bus_err || tmo == TW'(TMO - 1));
  assign fail    = bus_err || !bus_ack;
  assign rd_done = done && st == RD;
  assign hit     = host_wr && host_idx == cur;
  assign drop    = disc || hit;
  assign bad     = rd_done && !fail && !drop && bus_rdata != shadow[cur];

  assign go_wr = !busy && |pend;
  assign go_rd = !busy && !(|pend) && scanning && vld[cur];
  assign skip  = !busy && !(|pend) && scanning && !vld[cur];
  assign adv   = skip || rd_done;
  assign last  = cur == IW'(N - 1);
  assign start = !scanning && icnt >= scan_interval;

  assign wr_bit  = host_wr ? N'(1) << host_idx : '0;
  assign cur_bit = N'(1) << cur;
  assign mis_set = bad ? cur_bit : '0;
  assign com_set = (done && fail && !(st == RD && drop)) ? N'(1) << bus_idx : '0;
  assign clr     = host_clr ? host_clr_mask : '0;
  assign pend_n  = (pend & ~(go_wr ? N'(1) << widx : '0)) | wr_bit | mis_set;
  assign bus_req = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      vld <= '0;
      pend <= '0;
      cur <= '0;
      icnt <= '0;
      tmo <= '0;
      scanning <= 1'b0;
      disc <= 1'b0;
      bus_we <= 1'b0;
      bus_idx <= '0;
      bus_wdata <= '0;
      mis_flags <= '0;
      com_flags <= '0;
      summary <= '0;
      for (int i = 0; i < N; i++) shadow[i] <= '0;
    end else begin
      if (host_wr) shadow[host_idx] <= host_data;
      vld  <= vld | wr_bit;
      pend <= pend_n;
      mis_flags <= (mis_flags & ~clr) | mis_set;
      com_flags <= (com_flags & ~clr) | com_set;
      summary <= {6'b0, |com_flags, |mis_flags};

      if (start) icnt <= '0;
      else if (!(&icnt)) icnt <= icnt + 1'b1;

      if (start) begin
        scanning <= 1'b1;
        cur <= '0;
      end else if (adv) begin
        if (last) scanning <= 1'b0;
        cur <= cur + 1'b1;
      end

      tmo <= (busy && !done) ? tmo + 1'b1 : '0;

      if (go_rd) disc <= hit;
      else if (st == RD) disc <= disc || hit;

      case (st)
        IDLE: begin
          if (go_wr) begin
            st <= WR;
            bus_we <= 1'b1;
            bus_idx <= widx;
            bus_wdata <= shadow[widx];
          end else if (go_rd) begin
            st <= RD;
            bus_we <= 1'b0;
            bus_idx <= cur;
          end
        end
        default: if (done) st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/shadow_scrub_chk.sv
module shadow_scrub_chk #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic [IW-1:0] bus_idx,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack,
  input logic          bus_err,
  input logic          host_clr,
  input logic [N-1:0]  host_clr_mask,
  input logic [N-1:0]  mis_flags,
  input logic [N-1:0]  com_flags,
  input logic [7:0]    summary,
  input logic [N-1:0]  vld
);
  logic [N-1:0] clr_eff;
  assign clr_eff = host_clr ? host_clr_mask : '0;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err) |=> (!bus_req || $stable({bus_we, bus_idx, bus_wdata})));

  assert_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && (bus_ack || bus_err)) |=> !bus_req);

  assert_valid_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |-> vld[bus_idx]);

  assert_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (summary == {6'b0, |$past(com_flags), |$past(mis_flags)}));

  assert_sticky_mis_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(mis_flags) & ~$past(clr_eff)) & ~mis_flags) == '0));

  assert_sticky_com_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(com_flags) & ~$past(clr_eff)) & ~com_flags) == '0));
endmodule

bind shadow_scrub shadow_scrub_chk #(.N(N), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_idx(bus_idx),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err), .host_clr(host_clr),
  .host_clr_mask(host_clr_mask), .mis_flags(mis_flags), .com_flags(com_flags),
  .summary(summary), .vld(vld)
);

// File: tb/tb_shadow_scrub.sv
`timescale 1ns/1ps
module tb_shadow_scrub;
  localparam int N = 8, DW = 8, CW = 8, TMO = 6, IW = 3, SI = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, host_clr = 1'b0;
  logic [IW-1:0] host_idx = '0;
  logic [DW-1:0] host_data = '0;
  logic [N-1:0]  host_clr_mask = '0;
  logic [CW-1:0] scan_interval = 8'd255;
  logic bus_req, bus_we, bus_ack = 1'b0, bus_err = 1'b0;
  logic [IW-1:0] bus_idx;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic [N-1:0] mis_flags, com_flags;
  logic [7:0] summary;

  shadow_scrub #(.N(N), .DW(DW), .CW(CW), .TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_idx(host_idx), .host_data(host_data),
    .host_clr(host_clr), .host_clr_mask(host_clr_mask), .scan_interval(scan_interval),
    .bus_req(bus_req), .bus_we(bus_we), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .mis_flags(mis_flags), .com_flags(com_flags), .summary(summary));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stimulus-side model (written only by the main process)
  logic [DW-1:0] smodel [N];
  bit vmodel [N];
  bit silent [N];
  bit errm [N];
  int lat = 3;
  int phase = 0;
  int poke_seq = 0, poke_idx = 0;
  logic [DW-1:0] poke_val = '0;

  // bus target model
  logic [DW-1:0] tmem [N];
  int lc = 0, seen_poke = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 0; bus_err = 0; lc = 0;
      for (int i = 0; i < N; i++) tmem[i] = '0;
    end else begin
      if (poke_seq != seen_poke) begin
        tmem[poke_idx] = poke_val;
        seen_poke = poke_seq;
      end
      if (bus_ack || bus_err) begin
        bus_ack = 0; bus_err = 0; lc = 0;
      end else if (bus_req) begin
        if (!silent[bus_idx]) begin
          if (lc + 1 >= lat) begin
            lc = 0;
            if (errm[bus_idx]) bus_err = 1;
            else begin
              bus_ack = 1;
              if (bus_we) tmem[bus_idx] = bus_wdata;
              else bus_rdata = tmem[bus_idx];
            end
          end else lc++;
        end
      end else lc = 0;
    end
  end

  function automatic int next_valid(input int r);
    for (int k = 1; k <= N; k++) if (vmodel[(r + k) % N]) return (r + k) % N;
    return -1;
  endfunction

  // per-cycle monitor and reference comparison
  int cyc = 0, last_rd = -1, prev_r0 = -1, run = 0, max_run0 = 0;
  int wr_log[$];
  bit prev_req = 0, started = 0;
  logic [N-1:0] pmis = '0, pcom = '0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (bus_req && !prev_req) begin
        if (bus_we) begin
          wr_log.push_back(int'(bus_idx));
          chk(bus_wdata == smodel[bus_idx], "R1 write data", bus_wdata, smodel[bus_idx]);
        end else begin
          chk(vmodel[bus_idx], "R4 read of invalid entry", bus_idx, 0);
          if (last_rd >= 0)
            chk(int'(bus_idx) == next_valid(last_rd), "R4 scan order", bus_idx, next_valid(last_rd));
          last_rd = int'(bus_idx);
          if (bus_idx == 0 && phase == 3) begin
            if (prev_r0 >= 0) chk(cyc - prev_r0 == SI + 1, "R3 scan spacing", cyc - prev_r0, SI + 1);
            prev_r0 = cyc;
          end
        end
      end
      if (bus_req) run++; else run = 0;
      if (bus_req && !bus_we && bus_idx == 0 && run > max_run0) max_run0 = run;
      if (started)
        chk(summary == {6'b0, |pcom, |pmis}, "R9 summary", summary, {6'b0, |pcom, |pmis});
      started = 1;
      pmis = mis_flags;
      pcom = com_flags;
    end
    prev_req = bus_req;
  end

  task automatic hwrite(input int idx, input logic [DW-1:0] d);
    host_wr = 1; host_idx = IW'(idx); host_data = d;
    smodel[idx] = d; vmodel[idx] = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hclear(input logic [N-1:0] m);
    host_clr = 1; host_clr_mask = m;
    @(negedge clk);
    host_clr = 0; host_clr_mask = '0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      smodel[i] = '0; vmodel[i] = 0; silent[i] = 0; errm[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mis_flags == 0, "R10 mis after reset", mis_flags, 0);
    chk(com_flags == 0, "R10 com after reset", com_flags, 0);
    chk(summary == 0, "R10 summary after reset", summary, 0);
    chk(bus_req == 0, "R10 no request after reset", bus_req, 0);

    phase = 2;
    hwrite(5, 8'hA5);
    hwrite(0, 8'h3C);
    hwrite(2, 8'h96);
    repeat (30) @(negedge clk);
    chk(wr_log.size() == 3, "R2 write count", wr_log.size(), 3);
    if (wr_log.size() == 3) begin
      chk(wr_log[0] == 5, "R2 first write", wr_log[0], 5);
      chk(wr_log[1] == 0, "R2 lowest pending first", wr_log[1], 0);
      chk(wr_log[2] == 2, "R2 third write", wr_log[2], 2);
    end
    chk(tmem[5] == 8'hA5, "R1 target 5", tmem[5], 8'hA5);
    chk(tmem[0] == 8'h3C, "R1 target 0", tmem[0], 8'h3C);
    chk(tmem[2] == 8'h96, "R1 target 2", tmem[2], 8'h96);
    chk(last_rd == -1, "R3 no scan before interval", last_rd, -1);

    phase = 3;
    lat = 1;
    scan_interval = 8'(SI);
    repeat (120) @(negedge clk);
    chk(prev_r0 >= 0, "R3 scans started", prev_r0, 1);
    chk(mis_flags == 0, "R5 no mismatch on clean targets", mis_flags, 0);
    chk(com_flags == 0, "R6 no comm error on clean targets", com_flags, 0);

    phase = 4;
    poke_idx = 2; poke_val = 8'h69; poke_seq++;
    repeat (60) @(negedge clk);
    chk(mis_flags == 8'b0000_0100, "R5 mismatch flag", mis_flags, 8'b0000_0100);
    chk(com_flags == 0, "R5 no comm flag", com_flags, 0);
    chk(tmem[2] == 8'h96, "R5 target restored", tmem[2], 8'h96);
    chk(summary == 8'h01, "R9 summary mismatch", summary, 8'h01);

    phase = 5;
    errm[5] = 1;
    repeat (60) @(negedge clk);
    errm[5] = 0;
    chk(com_flags == 8'b0010_0000, "R6 error answer flag", com_flags, 8'b0010_0000);
    chk(mis_flags == 8'b0000_0100, "R6 mismatch untouched", mis_flags, 8'b0000_0100);
    silent[0] = 1;
    repeat (60) @(negedge clk);
    silent[0] = 0;
    chk(com_flags == 8'b0010_0001, "R6 timeout flag, R8 sticky", com_flags, 8'b0010_0001);
    chk(max_run0 == TMO, "R6 timeout length", max_run0, TMO);
    chk(summary == 8'h03, "R9 summary both", summary, 8'h03);

    phase = 6;
    hclear(8'b0000_0100);
    chk(mis_flags == 0, "R8 masked clear", mis_flags, 0);
    chk(com_flags == 8'b0010_0001, "R8 unmasked bits kept", com_flags, 8'b0010_0001);
    @(negedge clk);
    chk(summary == 8'h02, "R9 summary follows clear", summary, 8'h02);
    hclear(8'hFF);
    chk(com_flags == 0, "R8 full clear", com_flags, 0);
    @(negedge clk);
    chk(summary == 8'h00, "R9 summary zero", summary, 0);

    phase = 7;
    lat = 4;
    begin
      bit found = 0;
      for (int k = 0; k < 300 && !found; k++) begin
        @(negedge clk);
        if (bus_req && !bus_we && bus_idx == 2) found = 1;
      end
      chk(found, "R7 readback window reached", found, 1);
      if (found) hwrite(2, 8'h5A);
    end
    repeat (80) @(negedge clk);
    chk(mis_flags == 0, "R7 discarded readback", mis_flags, 0);
    chk(com_flags == 0, "R7 no comm flag", com_flags, 0);
    chk(tmem[2] == 8'h5A, "R7 new value written", tmem[2], 8'h5A);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule